// File: doc/BRIEF.md
# Periodic Tick Interrupt Coalescer

This block sits between a periodic timer and an interrupt controller. Every timer expiry that arrives on `tick_i` is counted as owed work. The block turns that backlog into interrupt pulses, and it never has more than one outstanding at a time. A new pulse goes out only when the previous one has been acknowledged, or when a configurable number of time-base units has elapsed since the last pulse. Ticks that arrive while the receiver is busy are therefore replayed later rather than lost.

An acknowledge arrives with a vector number. It retires one owed tick only when the vector equals the expected vector, the interrupt line is unmasked, and at least one tick is owed. The time base is a free-running count supplied from outside. Elapsed time is measured modulo its width, so wrap-around is harmless.

Top module: `tick_coalescer`

## Requirements
- R1: After reset, `irq_o` and `busy_o` are low, the owed count is zero and the block counts as acknowledged. A tick sampled at one rising edge produces an `irq_o` pulse after the following rising edge.
- R2: Every tick sampled without a valid acknowledge raises the owed count by one. `busy_o` is high exactly when the owed count is nonzero.
- R3: The owed count saturates at 2^CNT_W-1. Further ticks leave it there, so exactly 2^CNT_W-1 valid acknowledges drain a saturated backlog.
- R4: A tick and a valid acknowledge in the same cycle leave the owed count unchanged.
- R5: An acknowledge is valid when `ack_valid_i` is high, the owed count is nonzero, `ack_vec_i` equals `exp_vec_i` and `line_mask_i` is low (1 means masked). A valid acknowledge lowers the count by one and sets the acknowledged state.
- R6: An acknowledge with a wrong vector, with the line masked, or with nothing owed has no effect on the count or on the acknowledged state.
- R7: A pulse is issued in a cycle only when all three of these hold: the owed count is nonzero, `irq_o` is low, and either the block is acknowledged or (`time_i` − time of last issue) mod 2^TIME_W ≥ MAX_WAIT.
- R8: Each issue raises `irq_o` for exactly one cycle, clears the acknowledged state and records `time_i` as the issue time.
- R9: A valid acknowledge in the same cycle as an issue leaves the block acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer expiry, one per cycle high |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | VEC_W | Vector carried by the acknowledge |
| exp_vec_i | input | VEC_W | Vector the timer line is expected to use |
| line_mask_i | input | 1 | Timer line masked when high |
| time_i | input | TIME_W | Free-running time base |
| irq_o | output | 1 | One-cycle interrupt pulse |
| busy_o | output | 1 | High while ticks are owed |

## Verification
If the owed count is wrong, it shows on `busy_o` at the next rising edge: the flag either drops before the right number of valid acknowledges has arrived or stays high after them. A wrong acknowledged state or a wrong stored issue time shows on `irq_o` instead. With such a fault, the pulse either comes one cycle after a tick when it should be held, or it fails to come back exactly MAX_WAIT time units after the previous issue. The bench runs a cycle model that it compares against both outputs on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/tick_coal_pkg.sv
package tick_coal_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD = 2'b00,
      CNT_UP   = 2'b01,
      CNT_DOWN = 2'b10
   } cnt_op_e;

   function automatic cnt_op_e pick_op(input logic up, input logic down);
      if (up && !down)      return CNT_UP;
      else if (down && !up) return CNT_DOWN;
      else                  return CNT_HOLD;
   endfunction
endpackage

// File: rtl/tick_coal_ack_qual.sv
module tick_coal_ack_qual #(
   parameter int VEC_W = 8
) (
   input  logic             ack_valid_i,
   input  logic [VEC_W-1:0] ack_vec_i,
   input  logic [VEC_W-1:0] exp_vec_i,
   input  logic             line_mask_i,
   input  logic             pend_nz_i,
   output logic             ack_ok_o
);
   generate
      if (VEC_W < 1) begin : g_bad_vec
         $error("tick_coal_ack_qual: VEC_W must be at least 1");
      end
   endgenerate

   logic vec_match;
   assign vec_match = (ack_vec_i == exp_vec_i);
   assign ack_ok_o  = ack_valid_i && pend_nz_i && vec_match && !line_mask_i;
endmodule

// File: rtl/tick_coal_pend_ctr.sv
module tick_coal_pend_ctr
   import tick_coal_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inc_i,
   input  logic dec_i,
   output logic nz_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt
         $error("tick_coal_pend_ctr: CNT_W out of range 1..30");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d;
   cnt_op_e          op;

   assign op = pick_op(inc_i, dec_i);

   always_comb begin
      cnt_d = cnt_q;
      unique case (op)
         CNT_UP:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
         CNT_DOWN: if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign nz_o = (cnt_q != '0);

   a_r2_tick_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i && !dec_i && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
   a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i && !dec_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
   a_r4_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i && dec_i |=> $stable(cnt_q));
   a_r5_ack_subs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i && !inc_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tick_coal_issue.sv
module tick_coal_issue #(
   parameter int TIME_W     = 16,
   parameter int MAX_WAIT   = 1000,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pend_nz_i,
   input  logic              ack_ok_i,
   input  logic [TIME_W-1:0] time_i,
   output logic              irq_o
);
   generate
      if (TIME_W < 2 || TIME_W > 31) begin : g_bad_time
         $error("tick_coal_issue: TIME_W out of range 2..31");
      end
      if (MAX_WAIT < 1 || MAX_WAIT >= (1 << TIME_W)) begin : g_bad_wait
         $error("tick_coal_issue: MAX_WAIT must be in 1..2**TIME_W-1");
      end
   endgenerate

   localparam logic [TIME_W-1:0] WAIT_LIM = TIME_W'(MAX_WAIT);

   logic acked_q;
   logic irq_q;
   logic timed_out;
   logic issue;

   generate
      if (TIMEOUT_EN) begin : g_timeout
         logic [TIME_W-1:0] last_q;
         logic [TIME_W-1:0] elapsed;
         assign elapsed   = time_i - last_q;
         assign timed_out = (elapsed >= WAIT_LIM);
         always_ff @(posedge clk_i) begin
            if (!rst_ni)    last_q <= '0;
            else if (issue) last_q <= time_i;
         end
      end else begin : g_no_timeout
         logic unused_time;
         assign unused_time = ^time_i;
         assign timed_out   = 1'b0;
      end
   endgenerate

   assign issue = pend_nz_i && !irq_q && (acked_q || timed_out);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acked_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= issue;
         if (ack_ok_i)   acked_q <= 1'b1;
         else if (issue) acked_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;

   a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q);
   a_r8_clears_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue && !ack_ok_i |=> !acked_q);
   a_r9_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_ok_i |=> acked_q);
   a_r7_needs_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_nz_i |=> !irq_q);
endmodule

// File: rtl/tick_coalescer.sv
module tick_coalescer #(
   parameter int CNT_W      = 8,
   parameter int VEC_W      = 8,
   parameter int TIME_W     = 16,
   parameter int MAX_WAIT   = 1000,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              ack_valid_i,
   input  logic [VEC_W-1:0]  ack_vec_i,
   input  logic [VEC_W-1:0]  exp_vec_i,
   input  logic              line_mask_i,
   input  logic [TIME_W-1:0] time_i,
   output logic              irq_o,
   output logic              busy_o
);
   logic pend_nz;
   logic ack_ok;

   tick_coal_ack_qual #(.VEC_W(VEC_W)) u_qual (
      .ack_valid_i (ack_valid_i),
      .ack_vec_i   (ack_vec_i),
      .exp_vec_i   (exp_vec_i),
      .line_mask_i (line_mask_i),
      .pend_nz_i   (pend_nz),
      .ack_ok_o    (ack_ok)
   );

   tick_coal_pend_ctr #(.CNT_W(CNT_W)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (tick_i),
      .dec_i  (ack_ok),
      .nz_o   (pend_nz)
   );

   tick_coal_issue #(
      .TIME_W     (TIME_W),
      .MAX_WAIT   (MAX_WAIT),
      .TIMEOUT_EN (TIMEOUT_EN)
   ) u_issue (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pend_nz_i (pend_nz),
      .ack_ok_i  (ack_ok),
      .time_i    (time_i),
      .irq_o     (irq_o)
   );

   assign busy_o = pend_nz;

   a_r6_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && !tick_i |=> !busy_o);
   a_r5_drop_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !ack_ok |=> busy_o);
endmodule

// File: tb/tb_tick_coalescer.sv
module tb_tick_coalescer;
   localparam int CNT_W  = 6;
   localparam int VEC_W  = 8;
   localparam int TIME_W = 12;
   localparam int WAIT   = 40;
   localparam int PMAX   = (1 << CNT_W) - 1;
   localparam logic [VEC_W-1:0] EXP = 8'h20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, ackv = 1'b0, mask = 1'b0;
   logic [VEC_W-1:0]  avec = '0;
   logic [VEC_W-1:0]  evec = EXP;
   logic [TIME_W-1:0] tnow = '0;
   logic irq, busy;

   int checks = 0, errors = 0;
   int m_pend = 0;
   bit m_acked = 1'b1, m_irq = 1'b0;
   logic [TIME_W-1:0] m_last = '0;

   always #10 clk = ~clk;

   tick_coalescer #(.CNT_W(CNT_W), .VEC_W(VEC_W), .TIME_W(TIME_W), .MAX_WAIT(WAIT)) dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ack_valid_i(ackv),
      .ack_vec_i(avec), .exp_vec_i(evec), .line_mask_i(mask),
      .time_i(tnow), .irq_o(irq), .busy_o(busy));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit ack_good(input bit v, input logic [VEC_W-1:0] vec, input bit mk, input int p);
      return v && p != 0 && vec == EXP && !mk;
   endfunction

   function automatic bit may_issue(input int p, input bit ir, input bit ak,
                                    input logic [TIME_W-1:0] t, input logic [TIME_W-1:0] last);
      logic [TIME_W-1:0] el;
      el = t - last;
      return p != 0 && !ir && (ak || el >= TIME_W'(WAIT));
   endfunction

   task automatic step(input bit t, input bit v, input logic [VEC_W-1:0] vec,
                       input bit mk, input string req);
      bit ok, iss;
      @(negedge clk);
      chk(irq == m_irq, {req, " R7 R8 irq_o"}, int'(irq), int'(m_irq));
      chk(busy == (m_pend != 0), {req, " R2 busy_o"}, int'(busy), int'(m_pend != 0));
      tick = t; ackv = v; avec = vec; mask = mk;
      tnow = tnow + 1'b1;
      ok  = ack_good(v, vec, mk, m_pend);
      iss = may_issue(m_pend, m_irq, m_acked, tnow, m_last);
      if (t && !ok && m_pend < PMAX) m_pend++;
      else if (ok && !t)             m_pend--;
      if (ok)       m_acked = 1'b1;
      else if (iss) m_acked = 1'b0;
      if (iss) m_last = tnow;
      m_irq = iss;
   endtask

   task automatic drain(input string req, output int n);
      n = 0;
      while (busy && n < 200) begin
         step(0, 1, EXP, 0, req);
         n++;
         @(posedge clk); #1;
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      chk(irq == 1'b0, "R1 reset irq_o", int'(irq), 0);
      chk(busy == 1'b0, "R1 reset busy_o", int'(busy), 0);
      @(negedge clk); rst_n = 1'b1;

      // R1: first tick delivered right away
      step(1, 0, EXP, 0, "R1");
      step(0, 0, EXP, 0, "R1");
      step(0, 0, EXP, 0, "R1");
      chk(irq == 1'b1, "R1 first pulse", int'(irq), 1);
      // R6: wrong vector, masked
      step(1, 1, EXP + 1, 0, "R6");
      step(0, 1, EXP, 1, "R6");
      repeat (3) step(0, 0, EXP, 0, "R6");
      chk(irq == 1'b0, "R6 no re-issue without ack", int'(irq), 0);
      // R5 valid ack allows next issue
      step(0, 1, EXP, 0, "R5");
      repeat (3) step(0, 0, EXP, 0, "R5");
      // R7 timeout re-issue with no ack
      repeat (WAIT + 5) step(0, 0, EXP, 0, "R7");
      // R4 tick with valid ack
      step(1, 1, EXP, 0, "R4");
      step(0, 0, EXP, 0, "R4");
      drain("R5", n);
      // R6 ack with nothing owed
      step(0, 1, EXP, 0, "R6");
      step(0, 0, EXP, 0, "R6");
      chk(busy == 1'b0, "R6 idle ack", int'(busy), 0);
      // R3 saturation
      repeat (PMAX + 10) step(1, 0, EXP, 0, "R3");
      step(0, 0, EXP, 0, "R3");
      drain("R3", n);
      chk(n == PMAX, "R3 acks to drain", n, PMAX);

      // random phase, R9 hits occur when ack meets an issue
      for (int i = 0; i < 8000; i++) begin
         bit t, v, mk;
         logic [VEC_W-1:0] vec;
         t   = ($urandom % 4) == 0;
         v   = ($urandom % 3) == 0;
         mk  = ($urandom % 8) == 0;
         vec = (($urandom % 6) == 0) ? VEC_W'($urandom) : EXP;
         step(t, v, vec, mk, "R9 random");
      end
      step(0, 0, EXP, 0, "R2");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule